// File: doc/BRIEF.md
# Programmable line clamp and blanking generator

This block produces the per-line timing strobes of an image sensor readout path: an active-low optical-black clamp strobe, an active-low preblank strobe and an active-high horizontal blanking strobe. It also produces the pair of levels that the horizontal shift clocks must hold while blanking is active. All strobes are placed against a 12-bit pixel counter and a 12-bit line counter, and both counters follow the horizontal and vertical sync inputs.

Each strobe owns four stored sequences. A sequence is a short list of pixel positions at which the strobe changes state. The field is split into four line regions per strobe. Every strobe has its own region boundaries and its own per-region pointers, so a strobe can use a different sequence in each region. The blanking strobe can take up to six change positions, which allows extra pulses inside the blanking interval. Blanking can also be taken from an external pin with selectable polarity. All configuration arrives on static input vectors.

Top module: `line_clamp_blank_gen`

## Requirements
- R1: While reset is held, and for the first two clock edges after it is released, the outputs are hcnt_o=0, vcnt_o=0, clp_n_o=1, pbk_n_o=1, hblk_o=0, h13_lvl_o=0 and h24_lvl_o=1.
- R2: A falling edge on hd_i is a clock edge at which hd_i is sampled low after being sampled high. The edge 7 clocks after a falling edge loads hcnt_o with 0, and each falling edge has its own clear even if the next one comes before the clear. At every other edge hcnt_o increments by 1 and holds at 4095.
- R3: A falling edge on vd_i, detected like R2, loads vcnt_o with 0. Every hcnt_o clear increments vcnt_o by 1, up to a limit of 4095. The exception is the first clear after a vd_i falling edge, which leaves vcnt_o at 0. When the vd_i edge and an hcnt_o clear fall on the same clock edge, vcnt_o becomes 0 and the next clear increments it.
- R4: The clamp output is registered. After the edge at which the counter reads h, clp_n_o equals the start polarity clp_pol_i[s], XOR-ed once for each of the two toggle positions of sequence s that are less than or equal to h. Toggle t of sequence s sits at clp_tog_i[(2s+t)*12 +: 12]. A position the count never reaches has no effect, and the toggle order does not matter.
- R5: pbk_n_o follows R4 with its own inputs pbk_pol_i and pbk_tog_i, using the same bit positions.
- R6: With ext_sel_i=0, hblk_o is registered and starts each line at 0. It is inverted once for each of the six positions hbk_tog_i[(6s+t)*12 +: 12] of sequence s that are less than or equal to the pixel count.
- R7: The sequence s for a strobe is the pointer of the highest region r (1 to 3) whose boundary (*_chg_i[(r-1)*12 +: 12]) is at most the current line. If no such region exists, region 0 applies. The pointer of region r is *_ptr_i[2r +: 2], and each strobe uses its own boundaries and pointers.
- R8: The output h13_lvl_o is registered and equals hbk_mask_i[s] for the blanking sequence s selected by R7. h24_lvl_o is always its inverse.
- R9: With ext_sel_i=1, hblk_o at each edge takes ext_blk_i XOR ext_pol_i sampled at that edge. ext_pol_i=1 therefore means the external signal is active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_i | input | 1 | Horizontal sync, falling edge marks a line |
| vd_i | input | 1 | Vertical sync, falling edge marks a field |
| clp_pol_i | input | 4 | Clamp start polarity per sequence |
| clp_tog_i | input | 96 | Clamp toggle positions, 2 per sequence |
| clp_chg_i | input | 36 | Clamp region boundaries 1 to 3 |
| clp_ptr_i | input | 8 | Clamp sequence pointer per region |
| pbk_pol_i | input | 4 | Preblank start polarity per sequence |
| pbk_tog_i | input | 96 | Preblank toggle positions, 2 per sequence |
| pbk_chg_i | input | 36 | Preblank region boundaries 1 to 3 |
| pbk_ptr_i | input | 8 | Preblank sequence pointer per region |
| hbk_tog_i | input | 288 | Blanking toggle positions, 6 per sequence |
| hbk_mask_i | input | 4 | Shift clock level during blanking, per sequence |
| hbk_chg_i | input | 36 | Blanking region boundaries 1 to 3 |
| hbk_ptr_i | input | 8 | Blanking sequence pointer per region |
| ext_sel_i | input | 1 | 1 selects the external blanking input |
| ext_pol_i | input | 1 | 1 means the external blanking is active low |
| ext_blk_i | input | 1 | External blanking input |
| hcnt_o | output | 12 | Pixel counter |
| vcnt_o | output | 12 | Line counter |
| clp_n_o | output | 1 | Clamp strobe, active low |
| pbk_n_o | output | 1 | Preblank strobe, active low |
| hblk_o | output | 1 | Horizontal blanking, active high |
| h13_lvl_o | output | 1 | Level for shift clocks 1 and 3 during blanking |
| h24_lvl_o | output | 1 | Level for shift clocks 2 and 4 during blanking |

## Verification
Two events can land on the same clock edge: the line counter clear caused by a vertical sync falling edge, and the increment caused by the delayed horizontal clear. The bench provokes this by dropping vd_i exactly seven cycles after an hd_i falling edge. It then checks that the line counter reads 0 through that line and 1 on the next. The bench also sends lines four clocks long, so that a second horizontal clear is already queued when the first one is applied. The scoreboard compares the counters and every strobe, cycle by cycle, with its own reference model.

// File: rtl/lcb_pkg.sv
`timescale 1ns/1ps
package lcb_pkg;
  // Registered strobe bundle of the generator.
  typedef struct packed {
    logic clp_n;
    logic pbk_n;
    logic hblk;
    logic h13;
    logic h24;
  } lcb_out_t;

  // Idle levels: strobes inactive, clock levels complementary.
  localparam lcb_out_t LCB_OUT_IDLE = '{clp_n: 1'b1, pbk_n: 1'b1, hblk: 1'b0,
                                        h13: 1'b0, h24: 1'b1};
endpackage

// File: rtl/lcb_sync_cnt.sv
`timescale 1ns/1ps
module lcb_sync_cnt #(
  parameter int unsigned CW       = 12,
  parameter int unsigned HRST_DLY = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hd_i,
  input  logic          vd_i,
  output logic [CW-1:0] hcnt_o,
  output logic [CW-1:0] vcnt_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic                hd_q, vd_q;
  logic                hfall, vfall, line_start;
  logic [HRST_DLY-1:0] pipe_q, pipe_d;
  logic [CW-1:0]       hcnt_q, hcnt_d;
  logic [CW-1:0]       vcnt_q, vcnt_d;
  logic                vhold_q, vhold_d;
  logic                vcnt_en;

  assign hfall      = hd_q & ~hd_i;
  assign vfall      = vd_q & ~vd_i;
  assign line_start = pipe_q[HRST_DLY-1];

  // One delay stage per clock, so overlapping sync edges each keep their own clear.
  generate
    if (HRST_DLY > 1) begin : g_pipe_n
      assign pipe_d = {pipe_q[HRST_DLY-2:0], hfall};
    end else begin : g_pipe_1
      assign pipe_d = hfall;
    end
  endgenerate

  always_comb begin
    if (line_start) begin
      hcnt_d = '0;
    end else if (hcnt_q != CNT_MAX) begin
      hcnt_d = hcnt_q + 1'b1;
    end else begin
      hcnt_d = hcnt_q;
    end
  end

  // Field edge clears at once; the line start that follows it is absorbed.
  always_comb begin
    vcnt_en = vfall | line_start;
    vcnt_d  = vcnt_q;
    vhold_d = vhold_q;
    if (vfall) begin
      vcnt_d  = '0;
      vhold_d = ~line_start;
    end else if (line_start) begin
      if (vhold_q) begin
        vhold_d = 1'b0;
      end else if (vcnt_q != CNT_MAX) begin
        vcnt_d = vcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q    <= 1'b0;
      vd_q    <= 1'b0;
      pipe_q  <= '0;
      hcnt_q  <= '0;
      vcnt_q  <= '0;
      vhold_q <= 1'b0;
    end else begin
      hd_q   <= hd_i;
      vd_q   <= vd_i;
      pipe_q <= pipe_d;
      hcnt_q <= hcnt_d;
      if (vcnt_en) begin
        vcnt_q  <= vcnt_d;
        vhold_q <= vhold_d;
      end
    end
  end

  assign hcnt_o = hcnt_q;
  assign vcnt_o = vcnt_q;
endmodule

// File: rtl/lcb_region_sel.sv
`timescale 1ns/1ps
module lcb_region_sel #(
  parameter int unsigned CW   = 12,
  parameter int unsigned NREG = 4,
  parameter int unsigned SW   = 2
) (
  input  logic [CW-1:0]          line_i,
  input  logic [(NREG-1)*CW-1:0] chg_i,
  input  logic [NREG*SW-1:0]     ptr_i,
  output logic [SW-1:0]          seq_o
);
  // Ascending boundaries: the last one passed wins.
  always_comb begin
    seq_o = ptr_i[SW-1:0];
    for (int r = 1; r < NREG; r++) begin
      if (line_i >= chg_i[(r-1)*CW +: CW]) begin
        seq_o = ptr_i[r*SW +: SW];
      end
    end
  end
endmodule

// File: rtl/lcb_toggle_gen.sv
`timescale 1ns/1ps
module lcb_toggle_gen #(
  parameter int unsigned CW   = 12,
  parameter int unsigned NSEQ = 4,
  parameter int unsigned NTOG = 2,
  parameter int unsigned SW   = 2
) (
  input  logic [CW-1:0]           pix_i,
  input  logic [SW-1:0]           seq_i,
  input  logic [NSEQ-1:0]         pol_i,
  input  logic [NSEQ*NTOG*CW-1:0] tog_i,
  output logic                    lvl_o
);
  logic [NTOG-1:0] passed;

  // Level is a parity of positions already reached in the line.
  generate
    for (genvar t = 0; t < NTOG; t++) begin : g_cmp
      assign passed[t] = pix_i >= tog_i[(int'(seq_i)*NTOG + t)*CW +: CW];
    end
  endgenerate

  assign lvl_o = pol_i[seq_i] ^ (^passed);
endmodule

// File: rtl/line_clamp_blank_gen.sv
`timescale 1ns/1ps
module line_clamp_blank_gen #(
  parameter int unsigned CW       = 12,
  parameter int unsigned NSEQ     = 4,
  parameter int unsigned NREG     = 4,
  parameter int unsigned CLP_TOGS = 2,
  parameter int unsigned HB_TOGS  = 6,
  parameter int unsigned HRST_DLY = 7,
  localparam int unsigned SW      = (NSEQ > 1) ? $clog2(NSEQ) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hd_i,
  input  logic                       vd_i,
  input  logic [NSEQ-1:0]            clp_pol_i,
  input  logic [NSEQ*CLP_TOGS*CW-1:0] clp_tog_i,
  input  logic [(NREG-1)*CW-1:0]     clp_chg_i,
  input  logic [NREG*SW-1:0]         clp_ptr_i,
  input  logic [NSEQ-1:0]            pbk_pol_i,
  input  logic [NSEQ*CLP_TOGS*CW-1:0] pbk_tog_i,
  input  logic [(NREG-1)*CW-1:0]     pbk_chg_i,
  input  logic [NREG*SW-1:0]         pbk_ptr_i,
  input  logic [NSEQ*HB_TOGS*CW-1:0] hbk_tog_i,
  input  logic [NSEQ-1:0]            hbk_mask_i,
  input  logic [(NREG-1)*CW-1:0]     hbk_chg_i,
  input  logic [NREG*SW-1:0]         hbk_ptr_i,
  input  logic                       ext_sel_i,
  input  logic                       ext_pol_i,
  input  logic                       ext_blk_i,
  output logic [CW-1:0]              hcnt_o,
  output logic [CW-1:0]              vcnt_o,
  output logic                       clp_n_o,
  output logic                       pbk_n_o,
  output logic                       hblk_o,
  output logic                       h13_lvl_o,
  output logic                       h24_lvl_o
);
  import lcb_pkg::*;

  logic            rst_m_q, rst_s_n;
  logic [CW-1:0]   hcnt, vcnt;
  logic [SW-1:0]   clp_seq, pbk_seq, hbk_seq;
  logic            clp_lvl, pbk_lvl, hbk_lvl;
  logic [NSEQ-1:0] hbk_pol_zero;
  lcb_out_t        out_d, out_q;

  assign hbk_pol_zero = '0;

  // Reset asserts at once and leaves on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_n <= rst_m_q;
    end
  end

  lcb_sync_cnt #(.CW(CW), .HRST_DLY(HRST_DLY)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .hd_i(hd_i), .vd_i(vd_i),
    .hcnt_o(hcnt), .vcnt_o(vcnt)
  );

  lcb_region_sel #(.CW(CW), .NREG(NREG), .SW(SW)) u_clp_reg (
    .line_i(vcnt), .chg_i(clp_chg_i), .ptr_i(clp_ptr_i), .seq_o(clp_seq)
  );
  lcb_region_sel #(.CW(CW), .NREG(NREG), .SW(SW)) u_pbk_reg (
    .line_i(vcnt), .chg_i(pbk_chg_i), .ptr_i(pbk_ptr_i), .seq_o(pbk_seq)
  );
  lcb_region_sel #(.CW(CW), .NREG(NREG), .SW(SW)) u_hbk_reg (
    .line_i(vcnt), .chg_i(hbk_chg_i), .ptr_i(hbk_ptr_i), .seq_o(hbk_seq)
  );

  lcb_toggle_gen #(.CW(CW), .NSEQ(NSEQ), .NTOG(CLP_TOGS), .SW(SW)) u_clp_gen (
    .pix_i(hcnt), .seq_i(clp_seq), .pol_i(clp_pol_i), .tog_i(clp_tog_i), .lvl_o(clp_lvl)
  );
  lcb_toggle_gen #(.CW(CW), .NSEQ(NSEQ), .NTOG(CLP_TOGS), .SW(SW)) u_pbk_gen (
    .pix_i(hcnt), .seq_i(pbk_seq), .pol_i(pbk_pol_i), .tog_i(pbk_tog_i), .lvl_o(pbk_lvl)
  );
  lcb_toggle_gen #(.CW(CW), .NSEQ(NSEQ), .NTOG(HB_TOGS), .SW(SW)) u_hbk_gen (
    .pix_i(hcnt), .seq_i(hbk_seq), .pol_i(hbk_pol_zero), .tog_i(hbk_tog_i), .lvl_o(hbk_lvl)
  );

  always_comb begin
    out_d.clp_n = clp_lvl;
    out_d.pbk_n = pbk_lvl;
    out_d.hblk  = ext_sel_i ? (ext_blk_i ^ ext_pol_i) : hbk_lvl;
    out_d.h13   = hbk_mask_i[hbk_seq];
    out_d.h24   = ~hbk_mask_i[hbk_seq];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      out_q <= LCB_OUT_IDLE;
    end else begin
      out_q <= out_d;
    end
  end

  assign hcnt_o    = hcnt;
  assign vcnt_o    = vcnt;
  assign clp_n_o   = out_q.clp_n;
  assign pbk_n_o   = out_q.pbk_n;
  assign hblk_o    = out_q.hblk;
  assign h13_lvl_o = out_q.h13;
  assign h24_lvl_o = out_q.h24;
endmodule

// File: rtl/lcb_chk.sv
`timescale 1ns/1ps
module lcb_chk #(
  parameter int unsigned CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] hcnt,
  input logic [CW-1:0] vcnt,
  input logic          ext_sel,
  input logic          ext_pol,
  input logic          ext_blk,
  input logic          hblk,
  input logic          h13,
  input logic          h24
);
  localparam logic [CW-1:0] CMAX = '1;

  // R2
  hcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != '0) |-> ((hcnt == CW'($past(hcnt) + 1'b1)) ||
                      (hcnt == CMAX && $past(hcnt) == CMAX)));

  // R3
  vcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt != $past(vcnt)) |-> (vcnt == '0 || vcnt == CW'($past(vcnt) + 1'b1)));

  // R3
  vcnt_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt != '0 && vcnt != $past(vcnt)) |-> (hcnt == '0));

  // R9
  ext_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ext_sel) |-> (hblk == ($past(ext_blk) ^ $past(ext_pol))));

  // R8
  mask_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h24 == !h13));
endmodule

bind line_clamp_blank_gen lcb_chk #(.CW(CW)) u_lcb_chk (
  .clk(clk), .rst_n(rst_s_n), .hcnt(hcnt_o), .vcnt(vcnt_o),
  .ext_sel(ext_sel_i), .ext_pol(ext_pol_i), .ext_blk(ext_blk_i),
  .hblk(hblk_o), .h13(h13_lvl_o), .h24(h24_lvl_o)
);

// File: tb/line_clamp_blank_gen_tb_top.sv
`timescale 1ns/1ps
module line_clamp_blank_gen_tb_top;
  localparam int CW = 12, NSEQ = 4, NREG = 4, HBT = 6, DLY = 7, SW = 2;
  localparam logic [CW-1:0] MAXV = '1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, hd_i, vd_i, ext_sel_i, ext_pol_i, ext_blk_i;
  logic [NSEQ-1:0] clp_pol_i, pbk_pol_i, hbk_mask_i;
  logic [NSEQ*2*CW-1:0] clp_tog_i, pbk_tog_i;
  logic [NSEQ*HBT*CW-1:0] hbk_tog_i;
  logic [(NREG-1)*CW-1:0] clp_chg_i, pbk_chg_i, hbk_chg_i;
  logic [NREG*SW-1:0] clp_ptr_i, pbk_ptr_i, hbk_ptr_i;
  logic [CW-1:0] hcnt_o, vcnt_o;
  logic clp_n_o, pbk_n_o, hblk_o, h13_lvl_o, h24_lvl_o;

  line_clamp_blank_gen dut_i (
    .clk(clk), .rst_n(rst_n), .hd_i(hd_i), .vd_i(vd_i),
    .clp_pol_i(clp_pol_i), .clp_tog_i(clp_tog_i), .clp_chg_i(clp_chg_i), .clp_ptr_i(clp_ptr_i),
    .pbk_pol_i(pbk_pol_i), .pbk_tog_i(pbk_tog_i), .pbk_chg_i(pbk_chg_i), .pbk_ptr_i(pbk_ptr_i),
    .hbk_tog_i(hbk_tog_i), .hbk_mask_i(hbk_mask_i), .hbk_chg_i(hbk_chg_i), .hbk_ptr_i(hbk_ptr_i),
    .ext_sel_i(ext_sel_i), .ext_pol_i(ext_pol_i), .ext_blk_i(ext_blk_i),
    .hcnt_o(hcnt_o), .vcnt_o(vcnt_o), .clp_n_o(clp_n_o), .pbk_n_o(pbk_n_o),
    .hblk_o(hblk_o), .h13_lvl_o(h13_lvl_o), .h24_lvl_o(h24_lvl_o)
  );

  typedef struct packed {
    logic          rst;
    logic [CW-1:0] hc;
    logic [CW-1:0] vc;
    logic          clp, pbk, hb, h13, h24;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0, n_fail = 0;

  // Reference state, written from the requirements.
  logic m_hd, m_vd, m_hold;
  logic [DLY-1:0] m_pipe;
  logic [CW-1:0] m_hc, m_vc;
  int m_rst_left;

  function automatic logic [SW-1:0] ref_region(logic [CW-1:0] ln,
      logic [(NREG-1)*CW-1:0] chg, logic [NREG*SW-1:0] ptr);
    int r = 0;
    for (int i = NREG - 1; i >= 1; i--) begin
      if (r == 0 && ln >= chg[(i-1)*CW +: CW]) r = i;
    end
    return ptr[r*SW +: SW];
  endfunction

  function automatic logic ref_two(logic [CW-1:0] px, logic [SW-1:0] s,
      logic [NSEQ-1:0] pol, logic [NSEQ*2*CW-1:0] tg);
    logic l = pol[s];
    for (int t = 0; t < 2; t++) if (px >= tg[(int'(s)*2+t)*CW +: CW]) l = ~l;
    return l;
  endfunction

  function automatic logic ref_six(logic [CW-1:0] px, logic [SW-1:0] s,
      logic [NSEQ*HBT*CW-1:0] tg);
    logic l = 1'b0;
    for (int t = 0; t < HBT; t++) if (px >= tg[(int'(s)*HBT+t)*CW +: CW]) l = ~l;
    return l;
  endfunction

  // Called at a negedge; drives, predicts the next edge, returns at the next negedge.
  task automatic drive(input logic hd, input logic vd, input logic eb);
    exp_t e;
    logic hf, vf, ls;
    logic [SW-1:0] hs;
    hd_i = hd; vd_i = vd; ext_blk_i = eb;
    if (m_rst_left > 0) begin
      e = '{rst: 1'b1, hc: '0, vc: '0, clp: 1'b1, pbk: 1'b1, hb: 1'b0, h13: 1'b0, h24: 1'b1};
      m_rst_left--;
      m_hd = 1'b0; m_vd = 1'b0; m_hold = 1'b0; m_pipe = '0; m_hc = '0; m_vc = '0;
    end else begin
      e.rst = 1'b0;
      e.clp = ref_two(m_hc, ref_region(m_vc, clp_chg_i, clp_ptr_i), clp_pol_i, clp_tog_i);
      e.pbk = ref_two(m_hc, ref_region(m_vc, pbk_chg_i, pbk_ptr_i), pbk_pol_i, pbk_tog_i);
      hs    = ref_region(m_vc, hbk_chg_i, hbk_ptr_i);
      e.hb  = ext_sel_i ? (eb ^ ext_pol_i) : ref_six(m_hc, hs, hbk_tog_i);
      e.h13 = hbk_mask_i[hs];
      e.h24 = ~hbk_mask_i[hs];
      hf = m_hd & ~hd;
      vf = m_vd & ~vd;
      ls = m_pipe[DLY-1];
      if (ls) m_hc = '0;
      else if (m_hc != MAXV) m_hc = m_hc + 1'b1;
      if (vf) begin
        m_vc = '0;
        m_hold = ~ls;
      end else if (ls) begin
        if (m_hold) m_hold = 1'b0;
        else if (m_vc != MAXV) m_vc = m_vc + 1'b1;
      end
      m_pipe = {m_pipe[DLY-2:0], hf};
      m_hd = hd;
      m_vd = vd;
      e.hc = m_hc;
      e.vc = m_vc;
    end
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // One line: hd low in cycle 0, vd low in cycles [vs, vs+vl).
  task automatic line(input int len, input int vs, input int vl);
    for (int i = 0; i < len; i++)
      drive(i != 0, !(i >= vs && i < vs + vl), ((i % 5) < 2));
  endtask

  task automatic field(input int nlines, input int len, input int vs);
    line(len, vs, 3);
    for (int k = 1; k < nlines; k++) line(len, 0, 0);
  endtask

  task automatic cmp(input string tag, input string fld, input int got, input int expv);
    n_cmp++;
    if (got != expv) begin
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, fld, got, expv, $time);
    end
  endtask

  // Monitor: compares the item predicted for each edge, 1 ns after it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.rst ? "R1" : "R2", "hcnt", hcnt_o, e.hc);
        cmp(e.rst ? "R1" : "R3", "vcnt", vcnt_o, e.vc);
        cmp(e.rst ? "R1" : "R4 R7", "clp_n", clp_n_o, e.clp);
        cmp(e.rst ? "R1" : "R5 R7", "pbk_n", pbk_n_o, e.pbk);
        cmp(e.rst ? "R1" : "R6 R9", "hblk", hblk_o, e.hb);
        cmp(e.rst ? "R1" : "R8", "h13_lvl", h13_lvl_o, e.h13);
        cmp(e.rst ? "R1" : "R8", "h24_lvl", h24_lvl_o, e.h24);
      end
    end
  end

  task automatic set_tog2(inout logic [NSEQ*2*CW-1:0] v, input int s, input int a, input int b);
    v[(s*2)*CW +: CW] = CW'(a);
    v[(s*2+1)*CW +: CW] = CW'(b);
  endtask

  task automatic set_tog6(input int s, input int a, input int b, input int c,
                          input int d, input int f, input int g);
    hbk_tog_i[(s*HBT+0)*CW +: CW] = CW'(a);
    hbk_tog_i[(s*HBT+1)*CW +: CW] = CW'(b);
    hbk_tog_i[(s*HBT+2)*CW +: CW] = CW'(c);
    hbk_tog_i[(s*HBT+3)*CW +: CW] = CW'(d);
    hbk_tog_i[(s*HBT+4)*CW +: CW] = CW'(f);
    hbk_tog_i[(s*HBT+5)*CW +: CW] = CW'(g);
  endtask

  initial begin
    rst_n = 1'b0; hd_i = 1'b1; vd_i = 1'b1;
    ext_sel_i = 1'b0; ext_pol_i = 1'b0; ext_blk_i = 1'b0;
    m_rst_left = 1000000;
    // R4: clamp sequences, incl. reversed order and unreached toggle
    clp_pol_i = 4'b1011;
    clp_tog_i = '0;
    set_tog2(clp_tog_i, 0, 5, 10);
    set_tog2(clp_tog_i, 1, 2, 3);
    set_tog2(clp_tog_i, 2, 20, 4095);
    set_tog2(clp_tog_i, 3, 30, 12);
    // R5: preblank sequences, incl. a toggle at position 0
    pbk_pol_i = 4'b1101;
    pbk_tog_i = '0;
    set_tog2(pbk_tog_i, 0, 0, 3);
    set_tog2(pbk_tog_i, 1, 35, 4095);
    set_tog2(pbk_tog_i, 2, 8, 8);
    set_tog2(pbk_tog_i, 3, 20, 25);
    // R6: blanking, seq 1 uses all six toggles
    hbk_tog_i = '0;
    set_tog6(0, 1, 4, 4095, 4095, 4095, 4095);
    set_tog6(1, 2, 15, 5, 7, 9, 11);
    set_tog6(2, 3, 6, 4095, 4095, 4095, 4095);
    set_tog6(3, 10, 30, 12, 14, 4095, 4095);
    hbk_mask_i = 4'b0110;
    // R7: boundaries and pointers, separate per strobe
    clp_chg_i = {12'd6, 12'd4, 12'd2};
    clp_ptr_i = {2'd3, 2'd2, 2'd1, 2'd0};
    pbk_chg_i = {12'd5, 12'd3, 12'd1};
    pbk_ptr_i = {2'd0, 2'd1, 2'd2, 2'd3};
    hbk_chg_i = {12'd5, 12'd3, 12'd2};
    hbk_ptr_i = {2'd2, 2'd3, 2'd0, 2'd1};

    @(negedge clk);
    // R1: reset state while held and for two edges after release
    repeat (6) drive(1'b1, 1'b1, 1'b0);
    rst_n = 1'b1;
    m_rst_left = 2;
    repeat (5) drive(1'b1, 1'b1, 1'b0);

    // R2 R3 R4 R5 R6 R7 R8: regular fields
    repeat (3) field(8, 40, 0);
    // R3: vd falling edge on the same edge as the horizontal clear
    field(4, 40, 7);
    field(4, 40, 7);
    // R4: sequence change while running
    set_tog2(clp_tog_i, 0, 1, 38);
    field(8, 40, 0);
    // R9: external blanking, active high then active low
    ext_sel_i = 1'b1; ext_pol_i = 1'b0;
    field(4, 40, 0);
    ext_pol_i = 1'b1;
    field(4, 40, 0);
    ext_sel_i = 1'b0;
    // R2: lines shorter than the clear delay
    repeat (10) line(4, 0, 0);
    field(3, 40, 0);
    // R2: pixel counter saturation on a long line
    line(4110, 0, 0);
    // R3: line counter saturation
    repeat (4100) line(8, 0, 0);
    field(3, 40, 0);
    repeat (3) drive(1'b1, 1'b1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule